// File: doc/BRIEF.md
# Platform Control and Status Register Bank

This block is a small bank of 32-bit registers that a processor reaches over a simple request bus. It is decoded on the low address bits inside a 4 KB window. Most words are read-only status: a fixed build identity, a memory-ready indication, a packed clock-divider word that carries the live timer frequency, a build-option word listing the PCIe root ports that are present, and a memory-configuration word carrying the installed RAM size. One control word lets software ask for a whole-system reset.

The bank honours only full 32-bit accesses. Reads of any other width return zero, and writes of any other width are discarded. Offsets that hold no register read as zero and ignore writes. Writes to the status words change nothing. Every result is registered, so software-visible read data, the reset request and the access-error flag all appear one clock after the request.

Top module: `plat_ctrl_regs`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `rd_valid`, `rd_data`, `sys_rst_req` and `acc_err` are all zero.
- R2: Only size code 2 (4 bytes) is honoured; codes 0, 1 and 3 (1, 2, 8 bytes) read as zero, drop writes and raise `acc_err`.
- R3: Offsets 0x000, 0x004 and 0x008 (build identity words) read as 0x00000000.
- R4: Offset 0x014 (memory status) reads 0x00000005: bit 0 (locked) and bit 2 (calibrated) set.
- R5: Offset 0x030 (clock word) reads with bits [7:0] = 1 (first divide), [15:8] = `timer_mhz`, [23:16] = 1 (multiplier) and [31:24] = 1 (second divide).
- R6: Offset 0x034 (build options) reads with bit 0 clear and `pcie_en[2:0]` in bits [3:1], all other bits zero.
- R7: Offset 0x038 (memory config) reads with `ram_gb` in bits [3:0], bits [15:4] all ones, and bits [31:16] zero.
- R8: A 4-byte write to offset 0x010 with data bit 4 set gives exactly one cycle of `sys_rst_req` on the cycle after the write; the same write with bit 4 clear gives none.
- R9: Writes to offsets 0x000–0x018 and 0x030–0x038 do not change what those offsets read back afterwards, and no write other than the one in R8 raises `sys_rst_req`.
- R10: An access to any offset other than 0x000, 0x004, 0x008, 0x010, 0x014, 0x018, 0x030, 0x034 and 0x038 reads zero, is ignored on write, and raises `acc_err` for one cycle. Offsets 0x010 and 0x018 read as zero without an error.
- R11: `rd_valid` is high for exactly the cycle after each read request, and only then. `rd_data` is zero whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte offset of the access |
| req_size | input | 2 | Access width code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata | input | 32 | Write data |
| timer_mhz | input | 8 | Timer reference frequency in MHz |
| ram_gb | input | 4 | Installed RAM in GB |
| pcie_en | input | NUM_PCIE (3) | Presence of each PCIe root port |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| sys_rst_req | output | 1 | One-cycle system reset request |
| acc_err | output | 1 | One-cycle flag for a wrong-size or unmapped access |

## Verification
Every result is due exactly one clock after the request that caused it: read data with its valid, the reset pulse and the error flag. The bench model advances its expectation registers on the same rising edge the design does and compares all four outputs at the next falling edge. In this way a result that arrives a cycle early, a cycle late or lasts two cycles shows up as a mismatch. Status inputs are changed between accesses, so the fields that reflect them are checked against more than one value.

// File: rtl/plat_ctrl_regs.sv
module plat_ctrl_regs #(
  parameter int ADDR_W   = 16,
  parameter int NUM_PCIE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [7:0]        timer_mhz,
  input  logic [3:0]        ram_gb,
  input  logic [NUM_PCIE-1:0] pcie_en,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              sys_rst_req,
  output logic              acc_err
);
  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_ID0  = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFS_ID1  = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] OFS_ID2  = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] OFS_RST  = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] OFS_MEMS = ADDR_W'('h014);
  localparam logic [ADDR_W-1:0] OFS_PCIS = ADDR_W'('h018);
  localparam logic [ADDR_W-1:0] OFS_CLK  = ADDR_W'('h030);
  localparam logic [ADDR_W-1:0] OFS_OPTS = ADDR_W'('h034);
  localparam logic [ADDR_W-1:0] OFS_MEMC = ADDR_W'('h038);
  localparam int RST_BIT = 4;

  logic        size_ok, hit;
  logic [31:0] rval;

  assign size_ok = (req_size == SIZE_WORD);

  always_comb begin
    hit  = 1'b1;
    rval = 32'h0;
    case (req_addr)
      OFS_ID0, OFS_ID1, OFS_ID2, OFS_RST, OFS_PCIS: rval = 32'h0;
      OFS_MEMS: rval = 32'h0000_0005;
      OFS_CLK:  rval = {8'd1, 8'd1, timer_mhz, 8'd1};
      OFS_OPTS: rval = 32'({pcie_en, 1'b0});
      OFS_MEMC: rval = {16'h0, 12'hFFF, ram_gb};
      default:  hit  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_data     <= 32'h0;
      sys_rst_req <= 1'b0;
      acc_err     <= 1'b0;
    end else begin
      rd_valid    <= req_valid && !req_write;
      rd_data     <= (req_valid && !req_write && size_ok) ? rval : 32'h0;
      sys_rst_req <= req_valid && req_write && size_ok &&
                     (req_addr == OFS_RST) && req_wdata[RST_BIT];
      acc_err     <= req_valid && (!size_ok || !hit);
    end
  end
endmodule

// File: rtl/plat_ctrl_regs_chk.sv
module plat_ctrl_regs_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [31:0]       req_wdata,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              sys_rst_req,
  input logic              acc_err
);
  assert_badsize_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size != 2'd2) |=> (rd_valid && rd_data == 32'h0 && acc_err));

  assert_memstat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd2 && req_addr == ADDR_W'('h014))
      |=> (rd_data == 32'h0000_0005));

  assert_rst_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(req_valid && req_write && req_size == 2'd2 &&
                          req_addr == ADDR_W'('h010) && req_wdata[4]));

  assert_err_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(req_valid));

  assert_rdvalid_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 32'h0);
endmodule

bind plat_ctrl_regs plat_ctrl_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .sys_rst_req(sys_rst_req),
  .acc_err(acc_err));

// File: tb/plat_ctrl_regs_tb_top.sv
module plat_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  timer_mhz = 8'd50;
  logic [3:0]  ram_gb = 4'd1;
  logic [2:0]  pcie_en = 3'b111;
  logic rd_valid, sys_rst_req, acc_err;
  logic [31:0] rd_data;

  int checks = 0, errors = 0, cycles = 0;
  string cur_tag = "R11", exp_tag = "R1";

  bit e_rv = 0, e_rst = 0, e_err = 0;
  logic [31:0] e_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plat_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .timer_mhz(timer_mhz), .ram_gb(ram_gb), .pcie_en(pcie_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .sys_rst_req(sys_rst_req),
    .acc_err(acc_err));

  function automatic bit is_mapped(input int a);
    return a inside {'h000, 'h004, 'h008, 'h010, 'h014, 'h018, 'h030, 'h034, 'h038};
  endfunction

  function automatic logic [31:0] expect_word(input int a);
    logic [31:0] v = 0;
    if (a == 'h014) v = 5;
    else if (a == 'h030) v = 32'h0101_0001 | (32'(timer_mhz) << 8);
    else if (a == 'h034) v = 32'(pcie_en) * 2;
    else if (a == 'h038) v = 32'hFFF0 + 32'(ram_gb);
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    exp_tag = cur_tag;
    if (!rst_n) begin
      e_rv = 0; e_rd = 0; e_rst = 0; e_err = 0;
    end else begin
      e_rv  = req_valid && !req_write;
      e_rd  = (e_rv && req_size == 2) ? expect_word(int'(req_addr)) : 0;
      e_rst = req_valid && req_write && req_size == 2 && req_addr == 16'h010 && req_wdata[4];
      e_err = req_valid && (req_size != 2 || !is_mapped(int'(req_addr)));
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      chk(exp_tag, "rd_valid", 32'(rd_valid), 32'(e_rv));
      chk(exp_tag, "rd_data", rd_data, e_rd);
      chk(exp_tag, "sys_rst_req", 32'(sys_rst_req), 32'(e_rst));
      chk(exp_tag, "acc_err", 32'(acc_err), 32'(e_err));
    end
  end

  task automatic access(input bit wr, input int a, input int sz, input logic [31:0] wd, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 16'(a); req_size = 2'(sz); req_wdata = wd; cur_tag = tag;
    @(negedge clk);
    req_valid = 0; req_write = 0; cur_tag = "R11";
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset rd_valid", 32'(rd_valid), 0);
    chk("R1", "reset rd_data", rd_data, 0);
    chk("R1", "reset sys_rst_req", 32'(sys_rst_req), 0);
    chk("R1", "reset acc_err", 32'(acc_err), 0);
    rst_n = 1;
    @(negedge clk);
    // R3 identity words
    access(0, 'h000, 2, 0, "R3");
    access(0, 'h004, 2, 0, "R3");
    access(0, 'h008, 2, 0, "R3");
    // R4
    access(0, 'h014, 2, 0, "R4");
    // R5 with several timer values
    access(0, 'h030, 2, 0, "R5");
    timer_mhz = 8'd25;  access(0, 'h030, 2, 0, "R5");
    timer_mhz = 8'hFF;  access(0, 'h030, 2, 0, "R5");
    // R6
    access(0, 'h034, 2, 0, "R6");
    pcie_en = 3'b010;   access(0, 'h034, 2, 0, "R6");
    pcie_en = 3'b101;   access(0, 'h034, 2, 0, "R6");
    // R7
    access(0, 'h038, 2, 0, "R7");
    ram_gb = 4'd2;      access(0, 'h038, 2, 0, "R7");
    ram_gb = 4'hF;      access(0, 'h038, 2, 0, "R7");
    // R2 wrong sizes
    for (int s = 0; s < 4; s++) if (s != 2) access(0, 'h014, s, 0, "R2");
    for (int s = 0; s < 4; s++) if (s != 2) access(1, 'h010, s, 32'hFFFF_FFFF, "R2");
    // R8 reset request
    access(1, 'h010, 2, 32'h10, "R8");
    access(1, 'h010, 2, 32'hFFFF_FFEF, "R8");
    access(0, 'h010, 2, 0, "R10");
    // R9 writes to status words change nothing
    for (int a = 0; a <= 'h38; a += 4)
      if (is_mapped(a) && a != 'h010) begin
        access(1, a, 2, 32'hFFFF_FFFF, "R9");
        access(0, a, 2, 0, "R9");
      end
    // R10 unmapped offsets
    access(0, 'h00C, 2, 0, "R10");
    access(1, 'h01C, 2, 32'h10, "R10");
    access(0, 'h001, 2, 0, "R10");
    access(0, 'h03C, 2, 0, "R10");
    access(0, 'hFFC, 2, 0, "R10");
    access(0, 'h018, 2, 0, "R10");
    // R11 back-to-back reads then idle
    @(negedge clk);
    req_valid = 1; req_write = 0; req_size = 2; req_addr = 16'h014; cur_tag = "R11";
    @(negedge clk);
    req_addr = 16'h030;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule